// File: doc/BRIEF.md
# Pointer-Based Coherence Directory Slice

This block is one slice of a coherence directory for a protocol with Shared and Modified line states. The slice has one entry for every line that the private caches can hold. Each entry records its sharers as a short list of core-ID pointers, not as one presence bit per core. With 32 cores, each with a 1 KB private cache of 32-byte lines, the slice has 1024 entries. Each entry holds up to 16 pointers of 5 bits, so a sharer set costs 80 bits plus 16 occupancy bits.

A request carries an operation, the requesting core and a line slot number. The operation is a shared read, an exclusive read, an eviction or a query. The slice reads the entry and decides the new state and pointer list. It writes the entry back and returns a registered response one cycle later. The response holds the message kind and the list of target cores. These targets are the cores to invalidate, the owner to downgrade, or the current sharers for a query. It also gives the resulting state, the sharer count and an overflow flag.

Requests may arrive back to back, even to the same line. Each request sees the result of the one before it.

Top module: `dir_ptr_directory`

## Requirements
- R1: After reset every line is invalid and `rsp_valid` is low. A query to any line returns state 0 (invalid), count 0 and no targets.
- R2: A shared read (op 0) to an invalid line records only the requester. The line becomes state 1 (Shared) with count 1, and message 0 (none) is returned with no targets.
- R3: A shared read from a core not in a line that already has 16 pointers raises `rsp_overflow` for that response only. The line is left unchanged: still Shared, count 16, same sharers.
- R4: A shared read from a core already recorded for the line changes nothing. No message is sent and the count is kept, whether the line is Shared or Modified.
- R5: A shared read from another core to a Modified line returns message 2 (downgrade). Its single target is the owner. The line then becomes Shared and holds both the owner and the requester.
- R6: An exclusive read (op 1) returns message 1 (invalidate) targeting every recorded sharer except the requester. If there is no such sharer, it returns message 0. The line ends in state 2 (Modified) holding only the requester.
- R7: An eviction (op 2) removes the requester's pointer. Removing the last pointer makes the line invalid. An eviction from a core that is not recorded changes nothing.
- R8: A query (op 3) returns message 3 (list) with the current sharers as targets and does not alter the line.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. Back-to-back requests to different lines each get their own correct response.
- R10: Target slot k is reported as `rsp_tgt_ptr[k*5 +: 5]` (a core ID) and is valid when `rsp_tgt_vld[k]` is set. The set of valid target IDs is exactly the set of cores named by the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 shared read, 1 exclusive read, 2 eviction, 3 query |
| req_core | input | 5 | Requesting core ID |
| req_line | input | 10 | Line slot number |
| rsp_valid | output | 1 | Response present |
| rsp_msg | output | 2 | 0 none, 1 invalidate, 2 downgrade, 3 list |
| rsp_tgt_vld | output | 16 | Valid flag per target slot |
| rsp_tgt_ptr | output | 80 | Target core IDs, 5 bits per slot |
| rsp_state | output | 2 | Line state after the request: 0 I, 1 S, 2 M |
| rsp_count | output | 5 | Sharers recorded after the request |
| rsp_overflow | output | 1 | Shared read rejected because the pointer list is full |

## Verification
Most bad internal states show up in the response to the very next request to the same line.

- A stale or duplicated pointer shows up as a wrong target set or count on the next query or exclusive read.
- A lost occupancy bit shows up as a count below the number of sharers, or as a premature return to invalid on eviction.
- A wrong state is exposed when a shared read to that line fails to produce the expected downgrade.

The overflow corner is driven with 16 distinct sharers followed by a 17th. One slot is then freed and reused, to show that the full condition clears.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    OP_SHARE = 2'd0,
    OP_EXCL  = 2'd1,
    OP_EVICT = 2'd2,
    OP_QUERY = 2'd3
  } dir_op_e;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_MOD = 2'd2
  } dir_st_e;

  typedef enum logic [1:0] {
    MSG_NONE  = 2'd0,
    MSG_INVAL = 2'd1,
    MSG_DGRD  = 2'd2,
    MSG_LIST  = 2'd3
  } dir_msg_e;

endpackage

// File: rtl/dir_slot_scan.sv
module dir_slot_scan #(
  parameter int NUM_PTRS = 16,
  parameter int PTR_W    = 5
) (
  input  logic [NUM_PTRS-1:0]       slot_vld,
  input  logic [NUM_PTRS*PTR_W-1:0] slot_ptr,
  input  logic [PTR_W-1:0]          key,
  output logic                      hit,
  output logic [$clog2(NUM_PTRS)-1:0] hit_idx,
  output logic                      has_free,
  output logic [$clog2(NUM_PTRS)-1:0] free_idx,
  output logic [$clog2(NUM_PTRS+1)-1:0] cnt
);
  localparam int IDX_W = $clog2(NUM_PTRS);
  localparam int CNT_W = $clog2(NUM_PTRS+1);

  // lowest slot wins for both match and free search
  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    has_free = 1'b0;
    free_idx = '0;
    cnt      = '0;
    for (int k = NUM_PTRS-1; k >= 0; k--) begin
      if (slot_vld[k] && (slot_ptr[k*PTR_W +: PTR_W] == key)) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(k);
      end
      if (!slot_vld[k]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(k);
      end
      cnt = cnt + CNT_W'(slot_vld[k]);
    end
  end

endmodule

// File: rtl/dir_entry_next.sv
module dir_entry_next
  import dir_pkg::*;
#(
  parameter int NUM_PTRS = 16,
  parameter int PTR_W    = 5
) (
  input  dir_op_e                   op,
  input  logic [PTR_W-1:0]          core,
  input  dir_st_e                   cur_st,
  input  logic [NUM_PTRS-1:0]       cur_vld,
  input  logic [NUM_PTRS*PTR_W-1:0] cur_ptr,
  output dir_st_e                   nxt_st,
  output logic [NUM_PTRS-1:0]       nxt_vld,
  output logic [NUM_PTRS*PTR_W-1:0] nxt_ptr,
  output logic [$clog2(NUM_PTRS+1)-1:0] nxt_cnt,
  output dir_msg_e                  msg,
  output logic [NUM_PTRS-1:0]       tgt_vld,
  output logic                      overflow
);
  localparam int IDX_W = $clog2(NUM_PTRS);
  localparam int CNT_W = $clog2(NUM_PTRS+1);

  logic             hit, has_free;
  logic [IDX_W-1:0] hit_idx, free_idx;
  logic [CNT_W-1:0] cur_cnt;

  dir_slot_scan #(.NUM_PTRS(NUM_PTRS), .PTR_W(PTR_W)) scan_i (
    .slot_vld (cur_vld),
    .slot_ptr (cur_ptr),
    .key      (core),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .has_free (has_free),
    .free_idx (free_idx),
    .cnt      (cur_cnt)
  );

  always_comb begin
    nxt_st   = cur_st;
    nxt_vld  = cur_vld;
    nxt_ptr  = cur_ptr;
    msg      = MSG_NONE;
    tgt_vld  = '0;
    overflow = 1'b0;
    unique case (op)
      OP_SHARE: begin
        if (cur_st == ST_INV) begin
          nxt_st            = ST_SHR;
          nxt_vld           = '0;
          nxt_vld[0]        = 1'b1;
          nxt_ptr[PTR_W-1:0] = core;
        end else if (hit) begin
          // already recorded: nothing to do
        end else if (!has_free) begin
          overflow = 1'b1;
        end else begin
          nxt_vld[free_idx]                     = 1'b1;
          nxt_ptr[int'(free_idx)*PTR_W +: PTR_W] = core;
          nxt_st                                = ST_SHR;
          if (cur_st == ST_MOD) begin
            msg     = MSG_DGRD;
            tgt_vld = cur_vld;
          end
        end
      end
      OP_EXCL: begin
        tgt_vld = cur_vld;
        if (hit) tgt_vld[hit_idx] = 1'b0;
        if (|tgt_vld) msg = MSG_INVAL;
        nxt_st             = ST_MOD;
        nxt_vld            = '0;
        nxt_vld[0]         = 1'b1;
        nxt_ptr[PTR_W-1:0] = core;
      end
      OP_EVICT: begin
        if (hit) begin
          nxt_vld[hit_idx] = 1'b0;
          if (cur_cnt == CNT_W'(1)) nxt_st = ST_INV;
        end
      end
      OP_QUERY: begin
        msg     = MSG_LIST;
        tgt_vld = cur_vld;
      end
      default: ;
    endcase
  end

  always_comb begin
    nxt_cnt = '0;
    for (int k = 0; k < NUM_PTRS; k++) nxt_cnt = nxt_cnt + CNT_W'(nxt_vld[k]);
  end

endmodule

// File: rtl/dir_ptr_directory.sv
module dir_ptr_directory
  import dir_pkg::*;
#(
  parameter int NUM_CORES   = 32,
  parameter int NUM_PTRS    = 16,
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_BYTES  = 32
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          req_valid,
  input  logic [1:0]                                    req_op,
  input  logic [$clog2(NUM_CORES)-1:0]                  req_core,
  input  logic [$clog2(CACHE_BYTES/LINE_BYTES*NUM_CORES)-1:0] req_line,
  output logic                                          rsp_valid,
  output logic [1:0]                                    rsp_msg,
  output logic [NUM_PTRS-1:0]                           rsp_tgt_vld,
  output logic [NUM_PTRS*$clog2(NUM_CORES)-1:0]         rsp_tgt_ptr,
  output logic [1:0]                                    rsp_state,
  output logic [$clog2(NUM_PTRS+1)-1:0]                 rsp_count,
  output logic                                          rsp_overflow
);
  localparam int PTR_W          = $clog2(NUM_CORES);
  localparam int LINES_PER_CORE = CACHE_BYTES / LINE_BYTES;
  localparam int NUM_ENTRIES    = LINES_PER_CORE * NUM_CORES;
  localparam int CNT_W          = $clog2(NUM_PTRS+1);
  localparam int SET_W          = NUM_PTRS * PTR_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  // entry table
  dir_st_e             tab_st  [NUM_ENTRIES];
  logic [NUM_PTRS-1:0] tab_vld [NUM_ENTRIES];
  logic [SET_W-1:0]    tab_ptr [NUM_ENTRIES];

  dir_st_e             nxt_st;
  logic [NUM_PTRS-1:0] nxt_vld, tgt_vld;
  logic [SET_W-1:0]    nxt_ptr;
  logic [CNT_W-1:0]    nxt_cnt;
  dir_msg_e            msg;
  logic                overflow;

  dir_entry_next #(.NUM_PTRS(NUM_PTRS), .PTR_W(PTR_W)) next_i (
    .op       (dir_op_e'(req_op)),
    .core     (req_core),
    .cur_st   (tab_st[req_line]),
    .cur_vld  (tab_vld[req_line]),
    .cur_ptr  (tab_ptr[req_line]),
    .nxt_st   (nxt_st),
    .nxt_vld  (nxt_vld),
    .nxt_ptr  (nxt_ptr),
    .nxt_cnt  (nxt_cnt),
    .msg      (msg),
    .tgt_vld  (tgt_vld),
    .overflow (overflow)
  );

  logic tab_we;
  assign tab_we = req_valid;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        tab_st[e]  <= ST_INV;
        tab_vld[e] <= '0;
      end
    end else if (tab_we) begin
      tab_st[req_line]  <= nxt_st;
      tab_vld[req_line] <= nxt_vld;
    end
  end

  // pointer payload carries no reset; occupancy bits qualify it
  always_ff @(posedge clk) begin
    if (tab_we) tab_ptr[req_line] <= nxt_ptr;
  end

  // response register
  logic [SET_W-1:0] rsp_ptr_d;
  assign rsp_ptr_d = tab_ptr[req_line];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rsp_valid    <= 1'b0;
      rsp_msg      <= MSG_NONE;
      rsp_tgt_vld  <= '0;
      rsp_state    <= ST_INV;
      rsp_count    <= '0;
      rsp_overflow <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_overflow <= req_valid & overflow;
      if (req_valid) begin
        rsp_msg     <= msg;
        rsp_tgt_vld <= tgt_vld;
        rsp_state   <= nxt_st;
        rsp_count   <= nxt_cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) rsp_tgt_ptr <= rsp_ptr_d;
  end

  // checks on the response
  assert_mod_single_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (rsp_valid && rsp_state == ST_MOD) |-> (rsp_count == CNT_W'(1)));

  assert_inv_empty_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (rsp_valid && rsp_state == ST_INV) |-> (rsp_count == '0));

  assert_ovf_full_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_overflow |-> (rsp_valid && rsp_state == ST_SHR && rsp_count == CNT_W'(NUM_PTRS)));

  assert_dgrd_owner_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (rsp_valid && rsp_msg == MSG_DGRD) |->
      ($countones(rsp_tgt_vld) == 1 && rsp_state == ST_SHR && rsp_count == CNT_W'(2)));

  assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_valid == $past(req_valid));

endmodule

// File: tb/dir_ptr_directory_tb_top.sv
`timescale 1ns/1ps
module dir_ptr_directory_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [4:0]  req_core;
  logic [9:0]  req_line;
  logic        rsp_valid;
  logic [1:0]  rsp_msg;
  logic [15:0] rsp_tgt_vld;
  logic [79:0] rsp_tgt_ptr;
  logic [1:0]  rsp_state;
  logic [4:0]  rsp_count;
  logic        rsp_overflow;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  dir_ptr_directory dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_core(req_core), .req_line(req_line), .rsp_valid(rsp_valid),
    .rsp_msg(rsp_msg), .rsp_tgt_vld(rsp_tgt_vld), .rsp_tgt_ptr(rsp_tgt_ptr),
    .rsp_state(rsp_state), .rsp_count(rsp_count), .rsp_overflow(rsp_overflow)
  );

  localparam logic [1:0] SHR = 2'd0, EXC = 2'd1, EVI = 2'd2, QRY = 2'd3;
  localparam logic [1:0] M_NONE = 2'd0, M_INV = 2'd1, M_DG = 2'd2, M_LIST = 2'd3;
  localparam logic [1:0] S_I = 2'd0, S_S = 2'd1, S_M = 2'd2;

  function automatic logic [31:0] tgt_mask();
    logic [31:0] m = '0;
    for (int k = 0; k < 16; k++)
      if (rsp_tgt_vld[k]) m[rsp_tgt_ptr[k*5 +: 5]] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string tag, input logic [1:0] emsg, input logic [31:0] emask,
                     input logic [1:0] est, input int ecnt, input logic eovf);
    logic [31:0] am = tgt_mask();
    total++;
    if (rsp_valid !== 1'b1 || rsp_msg !== emsg || am !== emask || rsp_state !== est ||
        int'(rsp_count) != ecnt || rsp_overflow !== eovf) begin
      bad++;
      $display("FAIL %s: actual vld=%0b msg=%0d tgt=%h st=%0d cnt=%0d ovf=%0b expected vld=1 msg=%0d tgt=%h st=%0d cnt=%0d ovf=%0b",
               tag, rsp_valid, rsp_msg, am, rsp_state, rsp_count, rsp_overflow,
               emsg, emask, est, ecnt, eovf);
    end
  endtask

  task automatic chk_idle(input string tag);
    total++;
    if (rsp_valid !== 1'b0) begin
      bad++;
      $display("FAIL %s: actual rsp_valid=%0b expected 0", tag, rsp_valid);
    end
  endtask

  task automatic req(input logic [1:0] op, input int core, input int line, input string tag,
                     input logic [1:0] emsg, input logic [31:0] emask,
                     input logic [1:0] est, input int ecnt, input logic eovf);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_core = 5'(core); req_line = 10'(line);
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, emsg, emask, est, ecnt, eovf);
  endtask

  task automatic t_reset();
    chk_idle("R1 R9 idle after reset");
    req(QRY, 0, 0,    "R1 line 0 invalid",    M_LIST, 0, S_I, 0, 0);
    req(QRY, 0, 1023, "R1 line 1023 invalid", M_LIST, 0, S_I, 0, 0);
  endtask

  task automatic t_share();
    req(SHR, 10, 5, "R2 first sharer",       M_NONE, 0, S_S, 1, 0);
    req(SHR, 12, 5, "R10 second pointer",    M_NONE, 0, S_S, 2, 0);
    req(QRY, 0, 5,  "R8 R10 list 10 and 12", M_LIST, 32'h1400, S_S, 2, 0);
    req(SHR, 10, 5, "R4 repeat sharer",      M_NONE, 0, S_S, 2, 0);
  endtask

  task automatic t_excl();
    req(EXC, 12, 5, "R6 invalidate other",   M_INV, 32'h400, S_M, 1, 0);
    req(QRY, 0, 5,  "R6 owner only",         M_LIST, 32'h1000, S_M, 1, 0);
    req(EXC, 12, 5, "R6 owner re-excl",      M_NONE, 0, S_M, 1, 0);
    req(EXC, 20, 5, "R6 steal ownership",    M_INV, 32'h1000, S_M, 1, 0);
    req(QRY, 0, 5,  "R8 new owner",          M_LIST, 32'h100000, S_M, 1, 0);
  endtask

  task automatic t_downgrade();
    req(EXC, 3, 7, "R6 excl on invalid",     M_NONE, 0, S_M, 1, 0);
    req(SHR, 3, 7, "R4 owner share",         M_NONE, 0, S_M, 1, 0);
    req(SHR, 9, 7, "R5 downgrade owner",     M_DG, 32'h8, S_S, 2, 0);
    req(QRY, 0, 7, "R5 both recorded",       M_LIST, 32'h208, S_S, 2, 0);
  endtask

  task automatic t_evict();
    req(EVI, 20, 7, "R7 evict non-sharer",   M_NONE, 0, S_S, 2, 0);
    req(QRY, 0, 7,  "R7 unchanged list",     M_LIST, 32'h208, S_S, 2, 0);
    req(EVI, 3, 7,  "R7 evict one",          M_NONE, 0, S_S, 1, 0);
    req(QRY, 0, 7,  "R7 remaining list",     M_LIST, 32'h200, S_S, 1, 0);
    req(EVI, 9, 7,  "R7 evict last",         M_NONE, 0, S_I, 0, 0);
    req(QRY, 0, 7,  "R7 line freed",         M_LIST, 0, S_I, 0, 0);
    req(EXC, 1, 11, "R6 excl line 11",       M_NONE, 0, S_M, 1, 0);
    req(EVI, 1, 11, "R7 owner eviction",     M_NONE, 0, S_I, 0, 0);
  endtask

  task automatic t_overflow();
    for (int c = 0; c < 16; c++)
      req(SHR, c, 9, "R3 fill", M_NONE, 0, S_S, c + 1, 0);
    req(SHR, 16, 9, "R3 17th sharer",        M_NONE, 0, S_S, 16, 1);
    req(QRY, 0, 9,  "R3 set unchanged",      M_LIST, 32'hFFFF, S_S, 16, 0);
    req(SHR, 3, 9,  "R3 R4 present no ovf",  M_NONE, 0, S_S, 16, 0);
    req(EVI, 5, 9,  "R7 free a slot",        M_NONE, 0, S_S, 15, 0);
    req(SHR, 16, 9, "R3 reuse freed slot",   M_NONE, 0, S_S, 16, 0);
    req(QRY, 0, 9,  "R3 R10 final list",     M_LIST, 32'h1FFDF, S_S, 16, 0);
  endtask

  task automatic t_pipe();
    @(negedge clk);
    req_valid = 1'b1; req_op = SHR; req_core = 5'd4; req_line = 10'd12;
    @(negedge clk);
    chk("R9 first of pair", M_NONE, 0, S_S, 1, 0);
    req_op = EXC; req_core = 5'd6; req_line = 10'd13;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second of pair", M_NONE, 0, S_M, 1, 0);
    @(negedge clk);
    chk_idle("R9 idle gap");
    req(QRY, 0, 12, "R9 line 12 own",       M_LIST, 32'h10, S_S, 1, 0);
    req(QRY, 0, 13, "R9 line 13 own",       M_LIST, 32'h40, S_M, 1, 0);
    req(QRY, 0, 14, "R9 neighbour untouched", M_LIST, 0, S_I, 0, 0);
  endtask

  initial begin
    req_valid = 1'b0; req_op = '0; req_core = '0; req_line = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_share();
    t_excl();
    t_downgrade();
    t_evict();
    t_overflow();
    t_pipe();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    total++;
    bad++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule